// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor with Serial Configuration

This block watches over a microcontroller and drives an active-high reset line to it. Reset is asserted while the digital power-good input is low. After power-good returns, reset is stretched by a fixed settling delay before it releases. A watchdog timer runs while reset is inactive. If the firmware does not restart it within the selected interval, the watchdog forces a new reset, which is stretched by the same delay.

The firmware talks to the block over an SPI slave in mode 0. The chip-select line has two jobs: it frames transfers, and any falling edge on it also restarts the watchdog. The firmware can therefore service the watchdog simply by pulsing chip-select, with or without a command.

The watchdog interval is held in a two-bit configuration field that survives supervisor resets; only the system reset initialises it. A write-enable latch guards that field, so a configuration write takes effect only when the latch was set by an earlier command. All delays are counted in milliseconds from a prescaled system clock.

Top module: `wd_supervisor`

## Requirements
- R1: While `rst_n` is low, `reset_out` is 1. After `pwr_good` is high and `rst_n` is released, `reset_out` stays 1 for POR_MS milliseconds (200 by default, within one millisecond tick) and then goes to 0.
- R2: When `pwr_good` goes low, `reset_out` goes to 1 within a few clock cycles and stays 1 while `pwr_good` is low. After `pwr_good` returns high, `reset_out` releases POR_MS milliseconds later.
- R3: The two-bit timeout field selects the watchdog interval: 2'b00 is 1400 ms, 2'b01 is 600 ms and 2'b10 is 200 ms, counted from the last restart or from reset release. On expiry `reset_out` goes to 1 for POR_MS milliseconds and then releases.
- R4: Timeout field 2'b11 disables the watchdog, so `reset_out` never asserts from expiry.
- R5: A falling edge on `spi_csn` restarts the watchdog count from zero.
- R6: The SPI slave works in mode 0. Input is sampled on the rising edge of `spi_sck`, output changes on the falling edge, and the first 8 bits (MSB first) form the command. Command 8'h05 returns the status byte MSB first in the next 8 clocks. In that byte, bits [5:4] hold the timeout field, bit 1 holds the write-enable latch, and all other bits are 0.
- R7: Command 8'h06 sets the write-enable latch and command 8'h04 clears it.
- R8: Command 8'h01 followed by a data byte, issued while the latch is set, loads data bits [5:4] into the timeout field when the 16th bit is sampled. It ignores the other data bits and clears the latch.
- R9: Command 8'h01 issued while the latch is clear leaves the timeout field unchanged.
- R10: While `reset_out` is 1, the latch is held clear and the watchdog count is held at zero.
- R11: `spi_miso` is 0 while `spi_csn` is high.
- R12: The timeout field is 2'b00 after `rst_n` and keeps its value across resets caused by power-good loss or watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwr_good | input | 1 | Supply-good indication, asynchronous |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | SPI chip select (active low), also watchdog restart |
| spi_mosi | input | 1 | SPI data into the block |
| spi_miso | output | 1 | SPI data out of the block |
| reset_out | output | 1 | Active-high reset to the supervised processor |

## Verification
The assertions assume that `spi_sck`, `spi_csn` and `spi_mosi` are oversampled by the system clock. Each level of `spi_sck` must therefore last longer than the synchroniser and edge-detector latency, and `spi_mosi` must be settled well before each rising edge. The stimulus keeps each SCK half-period at eight system clocks. It changes MOSI only together with a falling SCK edge or while chip-select is high. Power-good changes are held for many milliseconds, and every chip-select pulse lasts at least two clocks, so each edge passes through the synchronisers intact.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    localparam logic [7:0] CMD_LATCH_SET = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;

    localparam int CMD_BITS   = 8;
    localparam int FRAME_BITS = 16;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/supv_tick.sv
module supv_tick #(
    parameter int CYCLES_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(CYCLES_PER_MS + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = (cnt_q == CW'(CYCLES_PER_MS - 1));
        cnt_d = wrap ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = wrap;
endmodule

// File: rtl/supv_spi.sv
module supv_spi
    import supv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       cs_s,
    input  logic       mosi_s,
    input  logic [7:0] status_i,
    output logic       miso_o,
    output logic       cs_fall_o,
    output logic       latch_set_o,
    output logic       latch_clr_o,
    output logic       wr_stb_o,
    output logic [1:0] wr_sel_o
);
    typedef struct packed {
        logic       sck_prev;
        logic       cs_prev;
        logic [4:0] bit_cnt;
        logic [7:0] rx;
        logic [7:0] cmd;
        logic [7:0] tx;
        logic       rd_act;
        logic       miso;
    } spi_st_t;

    spi_st_t q, d;
    logic       rise, fall;
    logic [7:0] rx_next;

    always_comb begin
        d           = q;
        latch_set_o = 1'b0;
        latch_clr_o = 1'b0;
        wr_stb_o    = 1'b0;
        rise        = sck_s & ~q.sck_prev;
        fall        = ~sck_s & q.sck_prev;
        rx_next     = {q.rx[6:0], mosi_s};
        wr_sel_o    = rx_next[5:4];
        cs_fall_o   = ~cs_s & q.cs_prev;
        d.sck_prev  = sck_s;
        d.cs_prev   = cs_s;

        if (cs_s) begin
            d.bit_cnt = '0;
            d.rd_act  = 1'b0;
            d.tx      = '0;
            d.miso    = 1'b0;
        end else begin
            if (rise && q.bit_cnt != 5'(FRAME_BITS)) begin
                d.rx      = rx_next;
                d.bit_cnt = q.bit_cnt + 5'd1;
                if (q.bit_cnt == 5'(CMD_BITS - 1)) begin
                    d.cmd = rx_next;
                    case (rx_next)
                        CMD_LATCH_SET: latch_set_o = 1'b1;
                        CMD_LATCH_CLR: latch_clr_o = 1'b1;
                        CMD_STAT_RD: begin
                            d.tx     = status_i;
                            d.rd_act = 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (q.bit_cnt == 5'(FRAME_BITS - 1) && q.cmd == CMD_STAT_WR) begin
                    wr_stb_o = 1'b1;
                end
            end
            if (fall && q.rd_act) begin
                d.miso = q.tx[7];
                d.tx   = {q.tx[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign miso_o = q.miso;
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
    import supv_pkg::*;
#(
    parameter int      POR_MS      = 200,
    parameter int      WD_SHORT_MS = 200,
    parameter int      WD_MID_MS   = 600,
    parameter int      WD_LONG_MS  = 1400,
    parameter wd_sel_e INIT_SEL    = WD_LONG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       pg_s,
    input  logic       cs_fall_i,
    input  logic       latch_set_i,
    input  logic       latch_clr_i,
    input  logic       wr_stb_i,
    input  logic [1:0] wr_sel_i,
    output logic       reset_o,
    output logic       wel_o,
    output wd_sel_e    sel_o,
    output logic       expire_o,
    output logic [31:0] wd_cnt_o
);
    localparam int WD_MAX = (WD_LONG_MS > WD_MID_MS)
                          ? ((WD_LONG_MS > WD_SHORT_MS) ? WD_LONG_MS : WD_SHORT_MS)
                          : ((WD_MID_MS  > WD_SHORT_MS) ? WD_MID_MS  : WD_SHORT_MS);
    localparam int WW = $clog2(WD_MAX + 1);
    localparam int HW = $clog2(POR_MS + 1);

    typedef struct packed {
        logic          rst_act;
        logic [HW-1:0] hold;
        logic [WW-1:0] wd;
        logic          wel;
        wd_sel_e       sel;
        logic          expire;
    } ctrl_st_t;

    ctrl_st_t      q, d;
    logic [WW-1:0] wd_last;

    always_comb begin
        case (q.sel)
            WD_SHORT: wd_last = WW'(WD_SHORT_MS - 1);
            WD_MID:   wd_last = WW'(WD_MID_MS - 1);
            default:  wd_last = WW'(WD_LONG_MS - 1);
        endcase
    end

    always_comb begin
        d        = q;
        d.expire = 1'b0;

        // configuration and write-enable latch
        if (wr_stb_i && q.wel) begin
            d.sel = wd_sel_e'(wr_sel_i);
            d.wel = 1'b0;
        end else if (latch_set_i) begin
            d.wel = 1'b1;
        end else if (latch_clr_i) begin
            d.wel = 1'b0;
        end
        if (q.rst_act) d.wel = 1'b0;

        // watchdog counter
        if (q.rst_act || q.sel == WD_OFF || cs_fall_i) begin
            d.wd = '0;
        end else if (tick_i) begin
            if (q.wd == wd_last) begin
                d.wd     = '0;
                d.expire = 1'b1;
            end else begin
                d.wd = q.wd + WW'(1);
            end
        end

        // reset stretcher
        if (!pg_s || q.expire) begin
            d.rst_act = 1'b1;
            d.hold    = '0;
        end else if (q.rst_act && tick_i) begin
            if (q.hold == HW'(POR_MS - 1)) begin
                d.rst_act = 1'b0;
                d.hold    = '0;
            end else begin
                d.hold = q.hold + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.rst_act <= 1'b1;
            q.hold    <= '0;
            q.wd      <= '0;
            q.wel     <= 1'b0;
            q.sel     <= INIT_SEL;
            q.expire  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign reset_o  = q.rst_act;
    assign wel_o    = q.wel;
    assign sel_o    = q.sel;
    assign expire_o = q.expire;
    assign wd_cnt_o = 32'(q.wd);
endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor
    import supv_pkg::*;
#(
    parameter int      CYCLES_PER_MS = 100000,
    parameter int      POR_MS        = 200,
    parameter int      WD_SHORT_MS   = 200,
    parameter int      WD_MID_MS     = 600,
    parameter int      WD_LONG_MS    = 1400,
    parameter int      SYNC_STAGES   = 2,
    parameter wd_sel_e INIT_SEL      = WD_LONG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic reset_out
);
    logic        pg_s, sck_s, cs_s, mosi_s;
    logic        tick;
    logic        cs_fall, latch_set, latch_clr, wr_stb;
    logic [1:0]  wr_sel;
    logic        wel, expire;
    wd_sel_e     sel;
    logic [1:0]  sel_bits;
    logic [7:0]  status;
    logic [31:0] wd_cnt;

    supv_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pwr_good, spi_sck, spi_csn, spi_mosi}),
        .dout ({pg_s, sck_s, cs_s, mosi_s})
    );

    supv_tick #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    assign sel_bits = sel;
    assign status   = {2'b00, sel_bits, 2'b00, wel, 1'b0};

    supv_spi u_spi (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (sck_s),
        .cs_s       (cs_s),
        .mosi_s     (mosi_s),
        .status_i   (status),
        .miso_o     (spi_miso),
        .cs_fall_o  (cs_fall),
        .latch_set_o(latch_set),
        .latch_clr_o(latch_clr),
        .wr_stb_o   (wr_stb),
        .wr_sel_o   (wr_sel)
    );

    supv_ctrl #(
        .POR_MS     (POR_MS),
        .WD_SHORT_MS(WD_SHORT_MS),
        .WD_MID_MS  (WD_MID_MS),
        .WD_LONG_MS (WD_LONG_MS),
        .INIT_SEL   (INIT_SEL)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .pg_s       (pg_s),
        .cs_fall_i  (cs_fall),
        .latch_set_i(latch_set),
        .latch_clr_i(latch_clr),
        .wr_stb_i   (wr_stb),
        .wr_sel_i   (wr_sel),
        .reset_o    (reset_out),
        .wel_o      (wel),
        .sel_o      (sel),
        .expire_o   (expire),
        .wd_cnt_o   (wd_cnt)
    );
endmodule

// File: rtl/wd_supervisor_chk.sv
module wd_supervisor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pg_s,
    input logic        cs_s,
    input logic        reset_out,
    input logic        spi_miso,
    input logic        wel,
    input logic [1:0]  sel_bits,
    input logic        expire,
    input logic [31:0] wd_cnt
);
    AST_RELEASE_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_out) |-> $past(pg_s)); // R1
    AST_PG_LOSS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> reset_out); // R2
    AST_EXPIRY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> reset_out); // R3
    AST_OFF_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bits == 2'b11) |=> !expire); // R4
    AST_LATCH_GUARDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |=> $stable(sel_bits)); // R9
    AST_LATCH_CLR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |=> !wel); // R10
    AST_WD_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |=> (wd_cnt == 32'd0)); // R10
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_miso); // R11
endmodule

bind wd_supervisor wd_supervisor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_s     (pg_s),
    .cs_s     (cs_s),
    .reset_out(reset_out),
    .spi_miso (spi_miso),
    .wel      (wel),
    .sel_bits (sel_bits),
    .expire   (expire),
    .wd_cnt   (wd_cnt)
);

// File: tb/wd_supervisor_test.sv
`timescale 1ns/1ps
module wd_supervisor_test;
    localparam int CPM  = 4;   // clocks per millisecond tick
    localparam int HALF = 8;   // clocks per SCK half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_csn = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic reset_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    wd_supervisor #(.CYCLES_PER_MS(CPM)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .spi_sck  (spi_sck),
        .spi_csn  (spi_csn),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .reset_out(reset_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ms(input int n);
        repeat (n * CPM) @(negedge clk);
    endtask

    task automatic wait_level(input logic lvl, input int max_ms, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < max_ms * CPM; i++) begin
            @(negedge clk);
            if (reset_out === lvl) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic spi_xfer(input logic [7:0] cmd, input logic [7:0] dat,
                            input int nbits, output logic [7:0] rd);
        rd = '0;
        @(negedge clk);
        spi_csn = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 8) ? cmd[7-i] : dat[15-i];
            repeat (HALF) @(negedge clk);
            if (i >= 8) rd[15-i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_csn  = 1'b1;
        spi_mosi = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        check(spi_miso === 1'b0, "R11", "miso with chip-select high", spi_miso, 0);
    endtask

    task automatic cmd8(input logic [7:0] cmd);
        logic [7:0] unused;
        spi_xfer(cmd, 8'h00, 8, unused);
    endtask

    task automatic write_cfg(input logic [7:0] val);
        logic [7:0] unused;
        spi_xfer(8'h01, val, 16, unused);
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] got;
        spi_xfer(8'h05, 8'h00, 16, got);
        check(got === exp, req, "status byte", got, exp);
    endtask

    task automatic kick();
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (2) @(negedge clk);
        spi_csn = 1'b1;
    endtask

    task automatic t_power_on();
        bit ok;
        rst_n = 1'b0; pwr_good = 1'b0;
        repeat (5) @(negedge clk);
        check(reset_out === 1'b1, "R1", "reset during rst_n", reset_out, 1);
        check(spi_miso === 1'b0, "R11", "miso idle after reset", spi_miso, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        pwr_good = 1'b1;
        wait_ms(197);
        check(reset_out === 1'b1, "R1", "reset before stretch ends", reset_out, 1);
        wait_level(1'b0, 6, ok);
        check(ok, "R1", "reset release after stretch", reset_out, 0);
    endtask

    task automatic t_latch();
        read_status("R12", 8'h00);
        cmd8(8'h06);
        read_status("R7", 8'h02);
        cmd8(8'h04);
        read_status("R7", 8'h00);
    endtask

    task automatic t_locked_write();
        write_cfg(8'h20);
        read_status("R9", 8'h00);
    endtask

    task automatic set_cfg(input logic [7:0] val, input logic [7:0] exp_stat);
        cmd8(8'h06);
        write_cfg(val);
        read_status("R8", exp_stat);
    endtask

    task automatic t_period(input int ms, input string req);
        bit ok;
        kick();
        wait_ms(ms - 3);
        check(reset_out === 1'b0, req, "no expiry before interval", reset_out, 0);
        wait_level(1'b1, 8, ok);
        check(ok, req, "expiry asserts reset", reset_out, 1);
        wait_ms(196);
        check(reset_out === 1'b1, req, "expiry reset stretched", reset_out, 1);
        wait_level(1'b0, 8, ok);
        check(ok, req, "expiry reset releases", reset_out, 0);
    endtask

    task automatic t_kicks();
        for (int k = 0; k < 6; k++) begin
            wait_ms(150);
            check(reset_out === 1'b0, "R5", "kicked watchdog stays quiet", reset_out, 0);
            kick();
        end
    endtask

    task automatic t_disabled();
        wait_ms(2000);
        check(reset_out === 1'b0, "R4", "disabled watchdog never expires", reset_out, 0);
    endtask

    task automatic t_power_loss();
        bit ok;
        set_cfg(8'h20, 8'h20);
        cmd8(8'h06);
        pwr_good = 1'b0;
        wait_ms(2);
        check(reset_out === 1'b1, "R2", "reset on power loss", reset_out, 1);
        wait_ms(50);
        check(reset_out === 1'b1, "R2", "reset held while power low", reset_out, 1);
        pwr_good = 1'b1;
        wait_ms(197);
        check(reset_out === 1'b1, "R2", "stretch after power return", reset_out, 1);
        wait_level(1'b0, 6, ok);
        check(ok, "R10", "release on time, watchdog held in reset", reset_out, 0);
        read_status("R10", 8'h20);
    endtask

    initial begin
        t_power_on();
        t_latch();
        t_locked_write();
        set_cfg(8'hEF, 8'h20);
        t_period(200, "R3");
        t_kicks();
        set_cfg(8'h10, 8'h10);
        t_period(600, "R3");
        set_cfg(8'h00, 8'h00);
        t_period(1400, "R3");
        set_cfg(8'h30, 8'h30);
        t_disabled();
        t_power_loss();
        read_status("R12", 8'h20);
        read_status("R6", 8'h20);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule